// File: doc/BRIEF.md
# Character LCD Power-Up Initializer

This block brings an 8-bit parallel character-LCD controller into a known operating mode after reset. The controller's own power-on state is one-line, small font, cursor incrementing and no display shift. That is rarely what a two-line module needs, so the block sends a fixed series of eight instructions. Each instruction goes to a lower-level bus engine over a request/done handshake. The bus engine drives the strobe and data pins and handles the register-select and read/write lines. Every byte this block sends is an instruction, with register-select 0 and write.

The sequence starts with a power-up wait. Three attention commands follow, and after each one the block waits for a fixed time instead of relying on the busy flag, because the flag cannot be trusted until the interface width is settled. Four further instructions are then sent, and each is complete as soon as the bus engine reports done: function set, display off, display on with the cursor style, and entry mode. A clear-display instruction ends the sequence. Five configuration inputs select the font height, cursor visibility, cursor blink, cursor direction and display shift. These inputs are captured once, when the power-up wait ends. When the last instruction is acknowledged, the ready output rises and stays high until the next reset.

The controller has five states. ST_POWER_WAIT counts out the power-up delay and captures the configuration; its transition is timer-expired → ST_ISSUE. ST_ISSUE holds the request high. It has three transitions on done:
- → ST_PAUSE for the three attention steps;
- → ST_READY for the last step;
- → ST_ADVANCE otherwise.

ST_PAUSE counts a fixed gap, with the transition timer-expired → ST_ADVANCE. ST_ADVANCE moves to the next step in one cycle, with the transition → ST_ISSUE. ST_READY is terminal until reset.

Top module: `lcd_boot_seq`

## Requirements
- R1: While reset is held, cmd_req and init_ready are 0. After reset is released, cmd_req stays low for PWRUP_US×CLK_MHZ clock edges. It rises on the edge that follows that count.
- R2: The first three requested bytes are each 0x30.
- R3: The fourth byte is function set: 0x38 with bit 2 equal to the captured font-tall setting (0x38 or 0x3C).
- R4: The fifth byte is 0x08 (display, cursor and blink all off).
- R5: The sixth byte is 0x0C with bit 1 equal to the captured cursor-on setting and bit 0 equal to the captured blink setting.
- R6: The seventh byte is entry mode: 0x04 with bit 1 equal to the captured move-right setting and bit 0 equal to the captured shift setting.
- R7: The eighth and final byte is 0x01 (clear display).
- R8: After done for the first, second and third attention commands, cmd_req stays low for (ATTN1_US, ATTN2_US, ATTN3_US)×CLK_MHZ + 1 cycles. After done for any later instruction, cmd_req is low for exactly one cycle before the next request.
- R9: cmd_req stays high with cmd_byte unchanged until a cycle in which cmd_done is high. It is low in the cycle that follows.
- R10: The configuration inputs are sampled only on the edge that ends the power-up wait. Later changes have no effect on the bytes sent.
- R11: init_ready rises in the cycle after done for the clear-display instruction. It then stays high with cmd_req low until reset.
- R12: A reset asserted partway through the sequence returns the block to the full power-up wait. The sequence restarts from the first attention command.
- R13: cmd_done has no effect when no request is outstanding, whether during the power-up wait, a pause or after ready.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_font_tall | input | 1 | 1 selects the taller 5x10 font |
| cfg_cursor_on | input | 1 | 1 shows the underline cursor |
| cfg_blink_on | input | 1 | 1 makes the cursor position blink |
| cfg_move_right | input | 1 | 1 moves the cursor right after each character |
| cfg_shift_disp | input | 1 | 1 shifts the whole display on each character |
| cmd_done | input | 1 | Bus engine has completed the requested instruction |
| cmd_req | output | 1 | Instruction request, held until done |
| cmd_byte | output | 8 | Instruction byte, valid while cmd_req is high |
| init_ready | output | 1 | Initialization sequence finished |

## Verification
The handshake assertions assume that the bus engine raises cmd_done only in response to a request and holds it for a single cycle. The bench meets this by driving done at a falling edge as a one-cycle pulse, after a chosen number of cycles of latency. Some tests deliberately pulse done while nothing is requested, to show that such pulses are ignored. The configuration-freeze checks assume that the inputs are valid when the power-up wait ends. The bench sets them before releasing reset and changes them only once at least one request has been seen.

// File: rtl/lcd_boot_pkg.sv
package lcd_boot_pkg;

    typedef enum logic [2:0] {
        ST_POWER_WAIT,
        ST_ISSUE,
        ST_PAUSE,
        ST_ADVANCE,
        ST_READY
    } boot_state_t;

    typedef struct packed {
        logic font_tall;
        logic cursor_on;
        logic blink_on;
        logic move_right;
        logic shift_disp;
    } boot_cfg_t;

    localparam int STEP_W     = 3;
    localparam int ATTN_COUNT = 3;
    localparam logic [STEP_W-1:0] LAST_STEP = 3'd7;

    localparam logic [7:0] OP_ATTN     = 8'h30;
    localparam logic [7:0] OP_FUNC     = 8'h38;
    localparam logic [7:0] OP_DISP_OFF = 8'h08;
    localparam logic [7:0] OP_DISP_ON  = 8'h0C;
    localparam logic [7:0] OP_ENTRY    = 8'h04;
    localparam logic [7:0] OP_CLEAR    = 8'h01;

endpackage

// File: rtl/lcd_boot_timer.sv
module lcd_boot_timer #(
    parameter int W       = 20,
    parameter int RST_VAL = 0
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         load,
    input  logic [W-1:0] load_val,
    output logic         zero
);

    logic [W-1:0] cnt_q;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_q <= W'(RST_VAL);
        end else if (load) begin
            cnt_q <= load_val;
        end else if (cnt_q != '0) begin
            cnt_q <= cnt_q - 1'b1;
        end
    end

    assign zero = (cnt_q == '0);

    // R8: once expired and not reloaded, the timer stays expired
    a_r8_zero_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        zero && !load |=> zero);

endmodule

// File: rtl/lcd_boot_cmdgen.sv
module lcd_boot_cmdgen
    import lcd_boot_pkg::*;
(
    input  logic [STEP_W-1:0] step,
    input  boot_cfg_t         cfg,
    output logic [7:0]        byte_out
);

    always_comb begin
        unique case (step)
            3'd0, 3'd1, 3'd2: byte_out = OP_ATTN;
            3'd3: byte_out = OP_FUNC | {5'b0, cfg.font_tall, 2'b0};
            3'd4: byte_out = OP_DISP_OFF;
            3'd5: byte_out = OP_DISP_ON | {6'b0, cfg.cursor_on, cfg.blink_on};
            3'd6: byte_out = OP_ENTRY | {6'b0, cfg.move_right, cfg.shift_disp};
            3'd7: byte_out = OP_CLEAR;
            default: byte_out = OP_CLEAR;
        endcase
    end

endmodule

// File: rtl/lcd_boot_seq.sv
module lcd_boot_seq
    import lcd_boot_pkg::*;
#(
    parameter int CLK_MHZ   = 50,
    parameter int PWRUP_US  = 15000,
    parameter int ATTN1_US  = 4100,
    parameter int ATTN2_US  = 100,
    parameter int ATTN3_US  = 40
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       cfg_font_tall,
    input  logic       cfg_cursor_on,
    input  logic       cfg_blink_on,
    input  logic       cfg_move_right,
    input  logic       cfg_shift_disp,
    input  logic       cmd_done,
    output logic       cmd_req,
    output logic [7:0] cmd_byte,
    output logic       init_ready
);

    localparam int PWRUP_CYC = PWRUP_US * CLK_MHZ;
    localparam int ATTN1_CYC = ATTN1_US * CLK_MHZ;
    localparam int ATTN2_CYC = ATTN2_US * CLK_MHZ;
    localparam int ATTN3_CYC = ATTN3_US * CLK_MHZ;
    localparam int TW        = $clog2(PWRUP_CYC + ATTN1_CYC + 1);

    boot_state_t       state_q;
    logic [STEP_W-1:0] step_q;
    boot_cfg_t         cfg_q;
    boot_cfg_t         cfg_in;
    logic              tmr_zero;
    logic              tmr_load;
    logic [TW-1:0]     gap_val;
    logic              is_attn;

    assign cfg_in = '{font_tall:  cfg_font_tall,
                      cursor_on:  cfg_cursor_on,
                      blink_on:   cfg_blink_on,
                      move_right: cfg_move_right,
                      shift_disp: cfg_shift_disp};

    assign is_attn = (step_q < STEP_W'(ATTN_COUNT));

    // Gap length for the attention step just acknowledged
    always_comb begin
        unique case (step_q[1:0])
            2'd0:    gap_val = TW'(ATTN1_CYC - 1);
            2'd1:    gap_val = TW'(ATTN2_CYC - 1);
            default: gap_val = TW'(ATTN3_CYC - 1);
        endcase
    end

    assign tmr_load = (state_q == ST_ISSUE) && cmd_done && is_attn;

    lcd_boot_timer #(
        .W       (TW),
        .RST_VAL (PWRUP_CYC - 1)
    ) u_timer (
        .clk      (clk),
        .rst_n    (rst_n),
        .load     (tmr_load),
        .load_val (gap_val),
        .zero     (tmr_zero)
    );

    lcd_boot_cmdgen u_cmdgen (
        .step     (step_q),
        .cfg      (cfg_q),
        .byte_out (cmd_byte)
    );

    // State register
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= ST_POWER_WAIT;
            step_q  <= '0;
            cfg_q   <= '0;
        end else begin
            unique case (state_q)
                ST_POWER_WAIT: begin
                    if (tmr_zero) begin
                        state_q <= ST_ISSUE;
                        cfg_q   <= cfg_in;
                    end
                end
                ST_ISSUE: begin
                    if (cmd_done) begin
                        if (is_attn)                  state_q <= ST_PAUSE;
                        else if (step_q == LAST_STEP) state_q <= ST_READY;
                        else                          state_q <= ST_ADVANCE;
                    end
                end
                ST_PAUSE: begin
                    if (tmr_zero) state_q <= ST_ADVANCE;
                end
                ST_ADVANCE: begin
                    step_q  <= step_q + 1'b1;
                    state_q <= ST_ISSUE;
                end
                ST_READY: begin
                    state_q <= ST_READY;
                end
                default: state_q <= ST_POWER_WAIT;
            endcase
        end
    end

    // Outputs
    always_comb begin
        cmd_req    = (state_q == ST_ISSUE);
        init_ready = (state_q == ST_READY);
    end

    // R9: request held with a stable byte until done
    a_r9_hold: assert property (@(posedge clk) disable iff (!rst_n)
        cmd_req && !cmd_done |=> cmd_req && $stable(cmd_byte));
    // R9: request drops right after done
    a_r9_drop: assert property (@(posedge clk) disable iff (!rst_n)
        cmd_req && cmd_done |=> !cmd_req);
    // R11: ready is sticky and excludes requests
    a_r11_ready_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        init_ready |=> init_ready && !cmd_req);
    // R2: attention steps carry the attention byte
    a_r2_attn_byte: assert property (@(posedge clk) disable iff (!rst_n)
        cmd_req && is_attn |-> cmd_byte == 8'h30);
    // R7: final step is clear display
    a_r7_clear_byte: assert property (@(posedge clk) disable iff (!rst_n)
        cmd_req && step_q == LAST_STEP |-> cmd_byte == 8'h01);
    // R10: captured configuration never changes after the power-up wait
    a_r10_cfg_frozen: assert property (@(posedge clk) disable iff (!rst_n)
        state_q != ST_POWER_WAIT |=> $stable(cfg_q));
    // R8: no request while a pause is still counting
    a_r8_pause_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        state_q == ST_PAUSE && !tmr_zero |=> !cmd_req);
    // R13: done while nothing is requested leaves the step unchanged
    a_r13_done_ignored: assert property (@(posedge clk) disable iff (!rst_n)
        !cmd_req && state_q != ST_ADVANCE |=> $stable(step_q));

endmodule

// File: tb/lcd_boot_seq_tb.sv
module lcd_boot_seq_tb;

    localparam int CLK_PERIOD = 10;
    localparam int CLK_MHZ    = 1;
    localparam int PWRUP      = 15000 * CLK_MHZ;
    localparam int GAP1       = 4100 * CLK_MHZ;
    localparam int GAP2       = 100 * CLK_MHZ;
    localparam int GAP3       = 40 * CLK_MHZ;

    // {cfg F,C,B,I,S ; pad ; latency ; function set ; display on ; entry mode}
    localparam logic [39:0] VEC [4] = '{
        {5'b00000, 3'd0, 8'd0, 8'h38, 8'h0C, 8'h04},
        {5'b11111, 3'd0, 8'd3, 8'h3C, 8'h0F, 8'h07},
        {5'b01010, 3'd0, 8'd1, 8'h38, 8'h0E, 8'h06},
        {5'b10101, 3'd0, 8'd5, 8'h3C, 8'h0D, 8'h05}
    };

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic cfg_font_tall = 1'b0, cfg_cursor_on = 1'b0, cfg_blink_on = 1'b0;
    logic cfg_move_right = 1'b0, cfg_shift_disp = 1'b0;
    logic cmd_done = 1'b0;
    logic cmd_req;
    logic [7:0] cmd_byte;
    logic init_ready;

    int n_cmp = 0;
    int n_bad = 0;
    bit finished = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    lcd_boot_seq #(.CLK_MHZ(CLK_MHZ)) u_dut (
        .clk            (clk),
        .rst_n          (rst_n),
        .cfg_font_tall  (cfg_font_tall),
        .cfg_cursor_on  (cfg_cursor_on),
        .cfg_blink_on   (cfg_blink_on),
        .cfg_move_right (cfg_move_right),
        .cfg_shift_disp (cfg_shift_disp),
        .cmd_done       (cmd_done),
        .cmd_req        (cmd_req),
        .cmd_byte       (cmd_byte),
        .init_ready     (init_ready)
    );

    task automatic check(input string tag, input int act, input int exp);
        n_cmp++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual 0x%0h expected 0x%0h", tag, act, exp);
        end
    endtask

    task automatic set_cfg(input logic [4:0] c);
        {cfg_font_tall, cfg_cursor_on, cfg_blink_on, cfg_move_right, cfg_shift_disp} = c;
    endtask

    task automatic do_reset(input logic [4:0] c);
        @(negedge clk);
        rst_n = 1'b0;
        cmd_done = 1'b0;
        set_cfg(c);
        repeat (3) @(negedge clk);
        check("R1 req in reset", int'(cmd_req), 0);
        check("R1 ready in reset", int'(init_ready), 0);
        rst_n = 1'b1;
    endtask

    // counts low samples starting at the current falling edge
    task automatic count_low(output int n);
        n = 0;
        while (!cmd_req) begin
            n++;
            @(negedge clk);
        end
    endtask

    // called at a falling edge with cmd_req high; ends at the edge after done
    task automatic serve(input int lat, output logic [7:0] b, output int stable);
        b = cmd_byte;
        stable = 1;
        for (int i = 0; i < lat; i++) begin
            @(negedge clk);
            if (!cmd_req || cmd_byte !== b) stable = 0;
        end
        cmd_done = 1'b1;
        @(negedge clk);
        cmd_done = 1'b0;
    endtask

    task automatic run_init(input logic [4:0] c, input int lat,
                            input logic [7:0] fs, input logic [7:0] dc,
                            input logic [7:0] em, input bit flip);
        int n;
        int st;
        logic [7:0] b;
        logic [7:0] exp_b;
        string tag;
        do_reset(c);
        @(negedge clk);
        count_low(n);
        check("R1 power-up wait", n, PWRUP - 1);
        for (int k = 0; k < 8; k++) begin
            case (k)
                0, 1, 2: begin exp_b = 8'h30; tag = "R2 attention"; end
                3: begin exp_b = fs; tag = flip ? "R10 function set" : "R3 function set"; end
                4: begin exp_b = 8'h08; tag = "R4 display off"; end
                5: begin exp_b = dc; tag = flip ? "R10 display on" : "R5 display on"; end
                6: begin exp_b = em; tag = flip ? "R10 entry mode" : "R6 entry mode"; end
                default: begin exp_b = 8'h01; tag = "R7 clear"; end
            endcase
            if (flip && k == 0) set_cfg(~c);
            serve(lat, b, st);
            check(tag, int'(b), int'(exp_b));
            check("R9 held stable", st, 1);
            if (k < 7) begin
                count_low(n);
                case (k)
                    0: check("R8 gap 1", n, GAP1 + 1);
                    1: check("R8 gap 2", n, GAP2 + 1);
                    2: check("R8 gap 3", n, GAP3 + 1);
                    default: check("R8 short gap", n, 1);
                endcase
            end else begin
                check("R11 ready after clear", int'(init_ready), 1);
                check("R11 no request at ready", int'(cmd_req), 0);
            end
        end
    endtask

    initial begin
        repeat (190000) @(posedge clk);
        if (!finished) begin
            n_bad++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    end

    initial begin
        int n;
        int st;
        logic [7:0] b;

        // table of configurations and expected bytes
        for (int r = 0; r < 4; r++) begin
            run_init(VEC[r][39:35], int'(VEC[r][31:24]),
                     VEC[r][23:16], VEC[r][15:8], VEC[r][7:0], 1'b0);
            if (r == 0) begin
                // R11 / R13: stray done after ready
                for (int i = 0; i < 10; i++) begin
                    cmd_done = 1'b1;
                    @(negedge clk);
                    cmd_done = 1'b0;
                    @(negedge clk);
                    check("R11 ready stays", int'(init_ready), 1);
                    check("R13 no request after ready", int'(cmd_req), 0);
                end
            end
        end

        // R10: configuration changed after capture is ignored
        run_init(5'b00000, 2, 8'h38, 8'h0C, 8'h04, 1'b1);

        // R12: reset in the middle of a pause restarts the whole wait
        do_reset(5'b10101);
        @(negedge clk);
        count_low(n);
        serve(0, b, st);
        repeat (50) @(negedge clk);
        rst_n = 1'b0;
        @(negedge clk);
        check("R12 req in mid reset", int'(cmd_req), 0);
        check("R12 ready in mid reset", int'(init_ready), 0);
        rst_n = 1'b1;
        // R13: done pulses during the power-up wait are ignored
        n = 0;
        for (int i = 0; i < 200; i++) begin
            @(negedge clk);
            cmd_done = i[0];
            if (!cmd_req) n++;
        end
        cmd_done = 1'b0;
        @(negedge clk);
        begin
            int m;
            count_low(m);
            n = n + m;
        end
        check("R12 R13 restart wait", n, PWRUP - 1);
        check("R12 restart byte", int'(cmd_byte), 8'h30);

        finished = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

endmodule